// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences one 10-bit successive-approximation conversion. The converter runs only while the enable input is held at 1. A one-cycle start pulse, accepted only when the enable has already been high for at least one cycle, raises busy. The block then waits one system cycle so that software can reach a low-power state. After that it runs an optional acquisition delay whose length a 3-bit code selects. It then opens the sample switch and works through the bit decisions from the most significant bit down. A two-period discharge interval follows. On completion, in a single clock edge, the block loads the result, drops busy, sets the interrupt flag and closes the sample switch again.

All phase timing counts periods of a conversion clock. That clock is a clock-enable pulse produced internally by dividing the system clock by a programmable ratio. The comparator and trial DAC live outside the block. The block presents the current trial code on a port and reads back one compare bit, which is 1 when the trial code does not exceed the sampled input.

Top module: `sar_conv_seq`

## Requirements
- R1: While `en_i` is 0, a start pulse is ignored and `busy_o` stays 0.
- R2: A start pulse in the same cycle in which `en_i` rises from 0 to 1 is ignored; a start is accepted only if `en_i` was also 1 in the previous cycle.
- R3: An accepted start holds `busy_o` high for exactly 1 + (A + 13) x P system cycles. P is the conversion-clock period and A is the acquisition length selected by `acq_sel_i` as 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20 periods.
- R4: `sample_o` (1 = switch closed) is 0 for exactly 13 conversion-clock periods of each completed operation: one setup period, ten bit periods and two discharge periods. It is 1 at all other times.
- R5: The loaded result equals the largest code whose compare bit reads 1. The block keeps a trial bit only if `cmp_i` is 1 while that bit is on trial.
- R6: Bits are decided from bit 9 down to bit 0, one per conversion-clock period. While a bit is on trial, it and every lower bit of the partial result are still 0.
- R7: On the cycle after the last discharge period, `result_o` takes the new value, `busy_o` falls, `irq_o` rises and `sample_o` returns to 1, all on the same edge. `irq_o` does not rise earlier.
- R8: Clearing `en_i` during an operation returns `busy_o` to 0 on the next edge. `result_o` keeps its previous value and `irq_o` is not set.
- R9: `irq_o` stays set until `irq_clr_i` is pulsed, and it clears on the edge that samples the pulse.
- R10: The conversion-clock period P is `clkdiv_i` + 1 system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable level |
| start_i | input | 1 | One-cycle start request |
| irq_clr_i | input | 1 | One-cycle clear of the completion flag |
| acq_sel_i | input | 3 | Acquisition length code |
| clkdiv_i | input | 4 | Conversion-clock divide value (period = value + 1) |
| cmp_i | input | 1 | Compare result: 1 when trial code does not exceed input |
| dac_o | output | 10 | Trial code sent to the external DAC |
| sample_o | output | 1 | Sample switch control, 1 = closed |
| busy_o | output | 1 | Operation in progress |
| result_o | output | 10 | Last completed conversion result |
| irq_o | output | 1 | Completion flag |

## Verification
The bench runs conversions against a comparator model for inputs 0x000, 0x3FF, 0x200, 0x1FF, 0x155 and 0x2AA. The all-ones and all-zeros codes reveal a stuck keep or drop decision. The 0x200/0x1FF pair reveals an error in bit order or in the compare sense, and the alternating codes reveal a swap between neighbouring bits. Each run uses a different pairing of acquisition code and divide value, so the busy length separates a wrong acquisition table from a wrong divider period, and the switch-open count isolates the setup and discharge periods. An abort mid-conversion, a start while disabled and a start in the same cycle as the enable cover the gating paths.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARM,
    PH_ACQ,
    PH_CONV,
    PH_DISCH
  } phase_e;

  localparam int ACQ_MAX = 20;

  // acquisition length in conversion-clock periods for each code
  function automatic logic [4:0] acq_periods(input logic [2:0] code);
    logic [4:0] len;
    case (code)
      3'd0:    len = 5'd0;
      3'd1:    len = 5'd2;
      3'd2:    len = 5'd4;
      3'd3:    len = 5'd6;
      3'd4:    len = 5'd8;
      3'd5:    len = 5'd12;
      3'd6:    len = 5'd16;
      default: len = 5'd20;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick); // R10

endmodule

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int DISCH_N = 2,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [2:0]       acq_sel,
  input  logic             tick,
  output logic             run,
  output logic             arm,
  output logic             bit_act,
  output logic [IDX_W-1:0] bit_idx,
  output logic             done,
  output logic             busy,
  output logic             sample
);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] acq_q, acq_d;
  logic [CNT_W-1:0] idx_full;
  logic             en_q;

  always_comb begin
    ph_d  = ph_q;
    per_d = per_q;
    acq_d = acq_q;
    if (!en) begin
      ph_d  = PH_IDLE;
      per_d = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start && en_q) begin
            ph_d  = PH_ARM;
            per_d = '0;
          end
        end
        PH_ARM: begin
          acq_d = CNT_W'(acq_periods(acq_sel));
          ph_d  = (acq_periods(acq_sel) == 5'd0) ? PH_CONV : PH_ACQ;
          per_d = '0;
        end
        PH_ACQ: begin
          if (tick) begin
            if (per_q == acq_q - 1'b1) begin
              ph_d  = PH_CONV;
              per_d = '0;
            end else begin
              per_d = per_q + 1'b1;
            end
          end
        end
        PH_CONV: begin
          if (tick) begin
            if (per_q == CNT_W'(RES_W)) begin
              ph_d  = PH_DISCH;
              per_d = '0;
            end else begin
              per_d = per_q + 1'b1;
            end
          end
        end
        PH_DISCH: begin
          if (tick) begin
            if (per_q == CNT_W'(DISCH_N - 1)) begin
              ph_d  = PH_IDLE;
              per_d = '0;
            end else begin
              per_d = per_q + 1'b1;
            end
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          per_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      per_q <= '0;
      acq_q <= '0;
      en_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      per_q <= per_d;
      acq_q <= acq_d;
      en_q  <= en;
    end
  end

  assign idx_full = CNT_W'(RES_W) - per_q;
  assign bit_idx  = idx_full[IDX_W-1:0];
  assign run      = (ph_q == PH_ACQ) || (ph_q == PH_CONV) || (ph_q == PH_DISCH);
  assign arm      = (ph_q == PH_ARM);
  assign bit_act  = (ph_q == PH_CONV) && (per_q != '0);
  assign done     = en && tick && (ph_q == PH_DISCH) && (per_q == CNT_W'(DISCH_N - 1));
  assign busy     = (ph_q != PH_IDLE);
  assign sample   = !((ph_q == PH_CONV) || (ph_q == PH_DISCH));

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !en_q) |=> (ph_q == PH_IDLE)); // R2

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && !en) |=> (ph_q == PH_IDLE)); // R8

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int RES_W = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_act,
  input  logic             tick,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp,
  input  logic             load,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-1:0] probe;
  logic [RES_W-1:0] low_mask;

  assign probe    = bit_act ? (RES_W'(1) << bit_idx) : '0;
  assign trial    = sar_q | probe;
  assign low_mask = (RES_W'(2) << bit_idx) - RES_W'(1);

  always_comb begin
    sar_d = sar_q;
    if (clr)                  sar_d = '0;
    else if (bit_act && tick) sar_d[bit_idx] = cmp;
    res_d = load ? sar_q : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      res_q <= '0;
    end else begin
      sar_q <= sar_d;
      res_q <= res_d;
    end
  end

  assign result = res_q;

  AST_LOWER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bit_act |-> ((sar_q & low_mask) == '0)); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(res_q)); // R8

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int DIV_W   = 4,
  parameter int DISCH_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             irq_clr_i,
  input  logic [2:0]       acq_sel_i,
  input  logic [DIV_W-1:0] clkdiv_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o,
  output logic             irq_o
);

  localparam int CNT_W = $clog2(((RES_W > ACQ_MAX) ? RES_W : ACQ_MAX) + 1);
  localparam int IDX_W = $clog2(RES_W);

  logic             rst_meta, rst_sync_n;
  logic             run, arm, bit_act, done, tick;
  logic [IDX_W-1:0] bit_idx;
  logic             irq_q, irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sar_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .div   (clkdiv_i),
    .tick  (tick)
  );

  sar_phase_fsm #(
    .RES_W   (RES_W),
    .DISCH_N (DISCH_N),
    .CNT_W   (CNT_W),
    .IDX_W   (IDX_W)
  ) i_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (en_i),
    .start   (start_i),
    .acq_sel (acq_sel_i),
    .tick    (tick),
    .run     (run),
    .arm     (arm),
    .bit_act (bit_act),
    .bit_idx (bit_idx),
    .done    (done),
    .busy    (busy_o),
    .sample  (sample_o)
  );

  sar_bit_reg #(.RES_W(RES_W), .IDX_W(IDX_W)) i_sar (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (arm),
    .bit_act (bit_act),
    .tick    (tick),
    .bit_idx (bit_idx),
    .cmp     (cmp_i),
    .load    (done),
    .trial   (dac_o),
    .result  (result_o)
  );

  always_comb begin
    if (done)           irq_d = 1'b1;
    else if (irq_clr_i) irq_d = 1'b0;
    else                irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> (!busy_o && sample_o)); // R7

  AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!en_i && !busy_o) |=> !busy_o); // R1

  AST_SWITCH_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sample_o |-> busy_o); // R4

endmodule

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_i, start_i, irq_clr_i;
  logic [2:0] acq_sel_i;
  logic [3:0] clkdiv_i;
  logic       cmp_i;
  logic [9:0] dac_o, result_o;
  logic       sample_o, busy_o, irq_o;
  logic [9:0] vin;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit fin   = 0;

  typedef struct {
    logic [9:0] res;
    int         busy_n;
    int         low_n;
    bit         irq;
    string      tag;
  } exp_t;

  exp_t       q[$];
  logic [9:0] last_res = '0;

  always #5 clk = ~clk;

  assign cmp_i = (dac_o <= vin);

  sar_conv_seq i_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i),
    .irq_clr_i(irq_clr_i), .acq_sel_i(acq_sel_i), .clkdiv_i(clkdiv_i),
    .cmp_i(cmp_i), .dac_o(dac_o), .sample_o(sample_o), .busy_o(busy_o),
    .result_o(result_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int acq_len(input logic [2:0] c);
    int t[8] = '{0, 2, 4, 6, 8, 12, 16, 20};
    return t[c];
  endfunction

  // monitor: measures each operation and compares against the queue
  int busy_cnt = 0, low_cnt = 0;
  bit was_busy = 0, irq_early = 0;
  always @(negedge clk) begin
    if (busy_o) begin
      busy_cnt++;
      if (!sample_o) low_cnt++;
      if (irq_o) irq_early = 1;
      was_busy = 1;
    end else if (was_busy) begin
      exp_t e;
      if (q.size() == 0) begin
        check(0, "R1", "unexpected operation", 1, 0);
      end else begin
        e = q.pop_front();
        check(busy_cnt == e.busy_n, e.tag, "busy cycles", busy_cnt, e.busy_n);   // R3 R10
        check(low_cnt == e.low_n, "R4", "switch-open cycles", low_cnt, e.low_n);
        check(result_o == e.res, "R5/R6", "result", result_o, e.res);
        check(irq_o == e.irq, e.irq ? "R7" : "R8", "flag at end", irq_o, e.irq);
        check(!irq_early && sample_o, "R7", "flag early or switch open", irq_early, 0);
      end
      busy_cnt = 0; low_cnt = 0; was_busy = 0; irq_early = 0;
    end
  end

  task automatic clear_irq();
    @(negedge clk) irq_clr_i = 1'b1;
    @(negedge clk) irq_clr_i = 1'b0;
  endtask

  task automatic do_conv(input logic [9:0] v, input logic [2:0] a,
                         input logic [3:0] d, input string tag);
    exp_t e;
    clear_irq();
    vin = v; acq_sel_i = a; clkdiv_i = d;
    e.res    = v;
    e.busy_n = 1 + (acq_len(a) + 13) * (int'(d) + 1);
    e.low_n  = 13 * (int'(d) + 1);
    e.irq    = 1'b1;
    e.tag    = tag;
    q.push_back(e);
    last_res = v;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; en_i = 1'b0; start_i = 1'b0; irq_clr_i = 1'b0;
    acq_sel_i = '0; clkdiv_i = '0; vin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check(busy_o == 1'b0, "R7", "reset busy", busy_o, 0);
    check(irq_o == 1'b0, "R9", "reset flag", irq_o, 0);
    check(result_o == '0, "R5", "reset result", result_o, 0);
    check(sample_o == 1'b1, "R4", "reset switch", sample_o, 1);

    // R1: start while disabled
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(busy_o == 1'b0, "R1", "busy after start while off", busy_o, 0);

    // R2: start in the same cycle as enable
    en_i = 1'b1; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(busy_o == 1'b0, "R2", "busy after start with enable", busy_o, 0);
    repeat (2) @(negedge clk);

    do_conv(10'h155, 3'd0, 4'd0, "R3");
    do_conv(10'h3FF, 3'd2, 4'd0, "R3");
    do_conv(10'h000, 3'd1, 4'd1, "R10");
    do_conv(10'h200, 3'd7, 4'd2, "R3");
    do_conv(10'h1FF, 3'd5, 4'd3, "R10");
    do_conv(10'h2AA, 3'd3, 4'd0, "R3");

    // R9: flag sticky, then cleared
    repeat (5) @(negedge clk);
    check(irq_o == 1'b1, "R9", "flag held", irq_o, 1);
    irq_clr_i = 1'b1;
    @(negedge clk) irq_clr_i = 1'b0;
    check(irq_o == 1'b0, "R9", "flag cleared", irq_o, 0);

    // R8: abort mid-conversion
    begin
      exp_t e;
      vin = 10'h0F0; acq_sel_i = 3'd0; clkdiv_i = 4'd1;
      e.res = last_res; e.busy_n = 7; e.low_n = 6; e.irq = 1'b0; e.tag = "R8";
      q.push_back(e);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      repeat (6) @(negedge clk);
      en_i = 1'b0;
      @(negedge clk);
      check(busy_o == 1'b0, "R8", "busy after abort", busy_o, 0);
      en_i = 1'b1;
      repeat (3) @(negedge clk);
      check(result_o == last_res, "R8", "result kept", result_o, last_res);
    end

    do_conv(10'h0F0, 3'd4, 4'd0, "R3");

    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      fin = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule